// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

This block sits behind a 12-bit sampling converter running at up to roughly one million samples per second. It thins the incoming stream by keeping one sample out of every N valid ones, and it records the kept samples without pause into a 1024-entry circular memory. While it records, it watches the kept samples for a crossing of a programmable threshold, in a chosen direction.

Once that crossing is seen, the block stores exactly 512 more kept samples and then stops. This leaves about half of the memory holding history from before the event. A full flag tells the host that the capture has ended. The host reads any entry through a read address, and uses the last-written address to find the oldest sample in the ring. A re-arm pulse then starts a fresh capture.

Top module: `capbuf_top`

## Requirements
- R1: After reset, `full` is 0, `lastAddr` is 0 and `rdData` is 0.
- R2: With a ratio of 1, every valid sample is written at the next sequential address, starting from 0 after re-arm. `lastAddr` gives the address of the most recent write. The address wraps from 1023 back to 0.
- R3: With a ratio N greater than 1, the first valid sample after re-arm is kept, and then every Nth valid sample after it. A ratio of 0 behaves as a ratio of 1.
- R4: Samples and threshold are compared as two's-complement signed values. With `slopeFall`=0, a kept sample triggers when the previous kept sample is below the threshold and the current one is at or above it. With `slopeFall`=1, it triggers when the previous one is above the threshold and the current one is at or below it.
- R5: After the triggering sample, exactly 512 more kept samples are written. `full` goes to 1 on the same clock edge that writes the 512th of them.
- R6: While `full` is 1, valid samples are ignored: `lastAddr` and the memory contents do not change.
- R7: A `rearm` pulse clears `full`, the write address, `lastAddr`, the decimation count and the trigger state. A sample that is valid in the same cycle as `rearm` is discarded.
- R8: `rdData` returns the memory word at `rdAddr` one clock after `rdAddr` is presented.
- R9: The kept-sample history is cleared on re-arm, so the first kept sample after a re-arm can never trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe marking a new sample |
| sampleIn | input | 12 | Signed sample |
| ratio | input | 8 | Decimation ratio N (0 acts as 1) |
| threshold | input | 12 | Signed trigger level |
| slopeFall | input | 1 | 0 = rising trigger, 1 = falling trigger |
| rearm | input | 1 | Pulse that restarts capture |
| rdAddr | input | 10 | Host read address |
| rdData | output | 12 | Stored word at rdAddr, one cycle later |
| lastAddr | output | 10 | Address of the most recent write |
| full | output | 1 | Capture complete, buffer frozen |

## Verification
Re-arm and a kept sample can fall in the same cycle. The bench provokes this by raising `rearm` and `sampleValid` together. It then checks that `lastAddr` has returned to 0 and that the next sample lands at address 0 rather than the dropped one. The end of capture can also coincide with further valid input. The bench judges this by pushing samples while `full` is set and confirming that both the last address and the next memory word keep their values.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic keep;  // write the current sample
    logic clr;   // restart: pointer and history cleared
  } capStrobe_t;
endpackage

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int RATIO_W  = 8,
  parameter int POST_CNT = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               rearm,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               crossHit,
  output capStrobe_t         stb,
  output logic               full
);
  localparam int CNT_W = $clog2(POST_CNT + 1);

  logic [RATIO_W-1:0] decCnt;
  logic [RATIO_W-1:0] ratioEff;
  logic [RATIO_W:0]   decInc;
  logic               triggered;
  logic [CNT_W-1:0]   remaining;
  logic               keep;

  assign ratioEff = (ratio == '0) ? RATIO_W'(1) : ratio;
  assign decInc   = {1'b0, decCnt} + 1'b1;
  assign keep     = sampleValid && !full && !rearm && (decCnt == '0);

  assign stb.keep = keep;
  assign stb.clr  = rearm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decCnt    <= '0;
      triggered <= 1'b0;
      remaining <= '0;
      full      <= 1'b0;
    end else if (rearm) begin
      decCnt    <= '0;
      triggered <= 1'b0;
      remaining <= '0;
      full      <= 1'b0;
    end else if (sampleValid && !full) begin
      decCnt <= (decInc >= {1'b0, ratioEff}) ? '0 : decInc[RATIO_W-1:0];
      if (keep) begin
        if (triggered) begin
          remaining <= remaining - 1'b1;
          if (remaining == CNT_W'(1)) full <= 1'b1;
        end else if (crossHit) begin
          triggered <= 1'b1;
          remaining <= CNT_W'(POST_CNT);
        end
      end
    end
  end

  // R7: a re-arm always leaves the block idle and untriggered
  a_r7_rearm_clears: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> (!full && !triggered));
  // R5: completion only ever follows a trigger
  a_r5_full_needs_trigger: assert property (@(posedge clk) disable iff (!rstN)
    full |-> triggered);
  // R5: post-trigger count never exceeds its window
  a_r5_remain_bound: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= CNT_W'(POST_CNT));
  // R9: once triggered, only a re-arm clears the trigger
  a_r9_trigger_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (triggered && !rearm) |=> triggered);
endmodule

// File: rtl/capbuf_datapath.sv
module capbuf_datapath
  import capbuf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  capStrobe_t          stb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                slopeFall,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic                crossHit,
  output logic [SAMPLE_W-1:0] rdData,
  output logic [ADDR_W-1:0]   lastAddr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]   wrPtr;
  logic [SAMPLE_W-1:0] prevSample;
  logic                prevValid;
  logic                riseHit;
  logic                fallHit;

  // Signed threshold crossing between previous and current kept sample
  always_comb begin
    riseHit  = ($signed(prevSample) <  $signed(threshold)) &&
               ($signed(sampleIn)   >= $signed(threshold));
    fallHit  = ($signed(prevSample) >  $signed(threshold)) &&
               ($signed(sampleIn)   <= $signed(threshold));
    crossHit = prevValid && (slopeFall ? fallHit : riseHit);
  end

  always_ff @(posedge clk) begin
    if (stb.keep) mem[wrPtr] <= sampleIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clr) begin
      wrPtr      <= '0;
      lastAddr   <= '0;
      prevSample <= '0;
      prevValid  <= 1'b0;
    end else if (stb.keep) begin
      wrPtr      <= wrPtr + 1'b1;
      lastAddr   <= wrPtr;
      prevSample <= sampleIn;
      prevValid  <= 1'b1;
    end
  end

  // R7: the control never asks for a write while restarting
  a_r7_clr_excludes_keep: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |-> !stb.keep);
  // R2: after any write the next slot follows the last one
  a_r2_ptr_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> (wrPtr == lastAddr + ADDR_W'(1)));
  // R2: last address moves only on a write or restart
  a_r2_last_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.keep && !stb.clr) |=> $stable(lastAddr));
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
  import capbuf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ADDR_W   = 10,
  parameter int RATIO_W  = 8,
  parameter int POST_CNT = 512
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [RATIO_W-1:0]  ratio,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                slopeFall,
  input  logic                rearm,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [SAMPLE_W-1:0] rdData,
  output logic [ADDR_W-1:0]   lastAddr,
  output logic                full
);
  capStrobe_t stb;
  logic       crossHit;

  capbuf_ctrl #(.RATIO_W(RATIO_W), .POST_CNT(POST_CNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rearm(rearm),
    .ratio(ratio), .crossHit(crossHit), .stb(stb), .full(full)
  );

  capbuf_datapath #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleIn(sampleIn),
    .threshold(threshold), .slopeFall(slopeFall), .rdAddr(rdAddr),
    .crossHit(crossHit), .rdData(rdData), .lastAddr(lastAddr)
  );

  // R6: a frozen buffer keeps its last address until re-armed
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (full && !rearm) |=> $stable(lastAddr));
endmodule

// File: tb/capbuf_top_tb_top.sv
module capbuf_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleIn = '0;
  logic [7:0]  ratio = 8'd1;
  logic [11:0] threshold = '0;
  logic        slopeFall = 1'b0;
  logic        rearm = 1'b0;
  logic [9:0]  rdAddr = '0;
  logic [11:0] rdData;
  logic [9:0]  lastAddr;
  logic        full;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  capbuf_top dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .ratio(ratio), .threshold(threshold), .slopeFall(slopeFall),
    .rearm(rearm), .rdAddr(rdAddr), .rdData(rdData),
    .lastAddr(lastAddr), .full(full)
  );

  typedef struct packed {
    logic        fall;
    logic [11:0] thr;
    logic [11:0] prev;
    logic [11:0] cur;
    logic        expTrig;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 12'd100, 12'd50,  12'd100, 1'b1},  // rising, equal counts
    '{1'b0, 12'd100, 12'd100, 12'd200, 1'b0},  // prev not below
    '{1'b0, 12'hFFB, 12'hF9C, 12'd0,   1'b1},  // signed: -100 -> 0 over -5
    '{1'b0, 12'd0,   12'h7FF, 12'h800, 1'b0},  // 2047 -> -2048 is not rising
    '{1'b1, 12'd100, 12'd101, 12'd100, 1'b1},  // falling, equal counts
    '{1'b1, 12'd100, 12'd200, 12'd150, 1'b0},  // stays above
    '{1'b1, 12'd0,   12'd5,   12'hFFF, 1'b1},  // signed: 5 -> -1
    '{1'b0, 12'd100, 12'd150, 12'd50,  1'b0}   // wrong direction
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] v);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = v;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic doRearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic readAt(input logic [9:0] a, output int v);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    v = int'(rdData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 full", int'(full), 0);
    check("R1 lastAddr", int'(lastAddr), 0);
    check("R1 rdData", int'(rdData), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 / R8: sequential fill with wrap, no trigger possible
    ratio = 8'd1; slopeFall = 1'b0; threshold = 12'h7FF;
    doRearm();
    for (int i = 0; i < 1030; i++) push(12'(i));
    check("R2 wrap lastAddr", int'(lastAddr), 5);
    readAt(10'd5, v);   check("R8 read wrapped word", v, 1029);
    readAt(10'd6, v);   check("R8 read unwrapped word", v, 6);
    readAt(10'd514, v); check("R8 read mid word", v, 514);

    // R3: decimation by 3, then ratio 0
    ratio = 8'd3;
    doRearm();
    for (int i = 0; i < 7; i++) push(12'(10 + i));
    check("R3 ratio3 lastAddr", int'(lastAddr), 2);
    readAt(10'd1, v); check("R3 ratio3 second kept", v, 13);
    readAt(10'd2, v); check("R3 ratio3 third kept", v, 16);
    ratio = 8'd0;
    doRearm();
    push(12'd20); push(12'd21);
    check("R3 ratio0 lastAddr", int'(lastAddr), 1);
    readAt(10'd1, v); check("R3 ratio0 word", v, 21);

    // R4 / R5: table of trigger cases
    ratio = 8'd1;
    foreach (VECS[k]) begin
      slopeFall = VECS[k].fall;
      threshold = VECS[k].thr;
      doRearm();
      push(VECS[k].prev);
      push(VECS[k].cur);
      for (int j = 0; j < 511; j++) push(VECS[k].cur);
      check($sformatf("R5 vec%0d full before last", k), int'(full), 0);
      push(VECS[k].cur);
      check($sformatf("R4 vec%0d trigger outcome", k), int'(full), int'(VECS[k].expTrig));
      if (VECS[k].expTrig)
        check($sformatf("R5 vec%0d lastAddr", k), int'(lastAddr), 513);
    end

    // R6: frozen buffer ignores input
    slopeFall = 1'b0; threshold = 12'd100;
    doRearm();
    push(12'd50); push(12'd100);
    for (int j = 0; j < 512; j++) push(12'(600 + j));
    check("R5 full after window", int'(full), 1);
    push(12'h123); push(12'h456);
    check("R6 lastAddr frozen", int'(lastAddr), 513);
    readAt(10'd514, v); check("R6 next word untouched", v, 514);
    readAt(10'd513, v); check("R6 last word intact", v, 600 + 511);
    doRearm();
    check("R7 rearm clears full", int'(full), 0);
    check("R7 rearm clears lastAddr", int'(lastAddr), 0);

    // R7: rearm and sample in the same cycle
    threshold = 12'h7FF;
    push(12'd1); push(12'd2); push(12'd3);
    @(negedge clk);
    rearm = 1'b1; sampleValid = 1'b1; sampleIn = 12'd77;
    @(negedge clk);
    rearm = 1'b0; sampleValid = 1'b0;
    check("R7 collision lastAddr", int'(lastAddr), 0);
    push(12'd88);
    readAt(10'd0, v); check("R7 collision sample dropped", v, 88);
    check("R7 collision next lastAddr", int'(lastAddr), 0);

    // R7: decimation count cleared
    ratio = 8'd3;
    doRearm();
    push(12'd31);
    doRearm();
    push(12'd30);
    readAt(10'd0, v); check("R7 decimation restarted", v, 30);
    ratio = 8'd1;

    // R9: history cleared, first kept sample cannot trigger
    threshold = 12'd100; slopeFall = 1'b0;
    doRearm();
    push(12'd50);
    doRearm();
    for (int j = 0; j < 513; j++) push(12'd150);
    check("R9 no trigger from stale history", int'(full), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule